// File: doc/BRIEF.md
# Byte-Lane Data Memory

This block is the data store of a 32-bit load/store processor core. It holds an array of 32-bit words and serves word, halfword and byte loads and stores. Width and signedness come from a 3-bit access-format code. A store changes only the byte lanes that the access covers. A load takes the addressed item out of the word and fills the upper bits with copies of the item's top bit or with zeros.

One processor cycle begins on the falling edge of the processor clock. The load is sampled on the rising edge in the middle of the cycle, which gives the address adder half a cycle to settle. The store commits on the edge that ends the cycle. Read and write therefore have separate clock inputs. The write clock is normally the inverted processor clock. A store is visible to a load in the next cycle. A load in the same cycle as a store still returns the old contents.

Top module: `byte_lane_dmem`

## Requirements
- R1: Format 3'b010 is a word access. A word store replaces all 32 bits of the addressed word, and a word load returns those 32 bits unchanged.
- R2: Format 3'b000 is a signed byte load. It returns the byte in lane address[1:0] (lane 0 = bits 7:0) and copies that byte's bit 7 into result bits 31:8.
- R3: Format 3'b100 is an unsigned byte load. It returns the addressed byte with result bits 31:8 set to zero.
- R4: Format 3'b001 is a signed halfword load. It returns bits 15:0 of the word when address[1] is 0 and bits 31:16 when address[1] is 1, with the halfword's bit 15 copied into result bits 31:16.
- R5: Format 3'b101 is an unsigned halfword load. It returns the addressed halfword with result bits 31:16 set to zero.
- R6: A byte store (format bits [1:0] = 00) writes write-data bits 7:0 into lane address[1:0] only. The other three bytes of the word keep their values.
- R7: A halfword store (format bits [1:0] = 01) writes write-data bits 15:0 into the half selected by address[1] only. The other half keeps its value.
- R8: The word index is taken from address bits [log2(DEPTH)+1:2]. Address bits above the index are ignored, and different indices hold independent words.
- R9: While the write enable is low, no storage bit changes, whatever the format, address or write data.
- R10: A load is sampled on the rising edge of the read clock and shows the contents from before any store in the same cycle. A store commits on the rising edge of the write clock and is visible to the next cycle's load.
- R11: While the active-low reset is low at a read-clock edge, the load data becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rd_clk | input | 1 | Read clock; the processor clock, sampled mid-cycle on its rising edge |
| wr_clk | input | 1 | Write clock; normally the inverted processor clock |
| rst_n | input | 1 | Synchronous active-low reset of the load-data path |
| addr | input | 32 | Byte address of the access |
| wdata | input | 32 | Store data, taken from the low bits for narrow stores |
| wen | input | 1 | Store enable |
| fmt | input | 3 | Access format: bits [1:0] select the width, bit 2 selects zero extension |
| rdata | output | 32 | Extended load data |

## Verification
Each word is first filled with a known word pattern. Narrow stores then land on chosen lanes, and word loads read back the whole word, which shows that the bytes outside the access kept their values. Loads of bytes and halves with the top bit set and with it clear separate sign extension from zero extension, and they show which lane is picked. A load in the same cycle as a store separates the read edge from the write edge. An address offset by the full depth, and stores with the enable low in byte and word formats, confirm that the index wraps and that disabled stores change nothing.

// File: rtl/dmem_pkg.sv
// Package: shared definitions for the byte-lane data memory.
// Assumes a 32-bit data word split into four byte lanes.
package dmem_pkg;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int LANE_AW = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } acc_size_e;

    localparam logic [2:0] FMT_WORD = 3'b010;

    // Width of the access; unlisted width codes fall back to a full word.
    function automatic acc_size_e size_of(input logic [2:0] fmt);
        case (fmt[1:0])
            2'b00:   return SZ_BYTE;
            2'b01:   return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

    // Format bit 2 requests zero extension on narrow loads.
    function automatic logic zero_ext(input logic [2:0] fmt);
        return fmt[2];
    endfunction
endpackage

// File: rtl/dmem_lane_ctl.sv
// Module: store lane control.
// Turns the format, the low address bits and the enable into one write
// strobe per byte lane, and copies the narrow store data onto every lane.
// Assumes naturally aligned halfword and word accesses.
module dmem_lane_ctl
    import dmem_pkg::*;
(
    input  logic [LANE_AW-1:0] lane,
    input  logic               wen,
    input  logic [2:0]         fmt,
    input  logic [DATA_W-1:0]  wdata,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  wlane
);
    acc_size_e sz;

    assign sz = size_of(fmt);

    // Purpose: enable only the lanes that the access covers.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic [LANE_AW-1:0] li;
            li = LANE_AW'(i);
            unique case (sz)
                SZ_BYTE: be[i] = wen && (li == lane);
                SZ_HALF: be[i] = wen && (li[1] == lane[1]);
                default: be[i] = wen;
            endcase
        end
    end

    // Purpose: place the store data on every lane it may land in.
    always_comb begin
        unique case (sz)
            SZ_BYTE: wlane = {LANES{wdata[7:0]}};
            SZ_HALF: wlane = {(LANES/2){wdata[15:0]}};
            default: wlane = wdata;
        endcase
    end
endmodule

// File: rtl/dmem_load_ext.sv
// Module: load extraction and extension.
// Picks the addressed byte or halfword out of a word that was read, then
// fills the upper bits by sign or by zero as the format asks.
// Assumes the lane and the format were captured with the word.
module dmem_load_ext
    import dmem_pkg::*;
(
    input  logic [DATA_W-1:0]  word,
    input  logic [LANE_AW-1:0] lane,
    input  logic [2:0]         fmt,
    output logic [DATA_W-1:0]  rdata
);
    logic [7:0]  byte_v;
    logic [15:0] half_v;

    // Purpose: select the addressed byte and halfword.
    always_comb begin
        byte_v = word[{lane, 3'b000} +: 8];
        half_v = word[{lane[1], 4'b0000} +: 16];
    end

    // Purpose: extend the selected item to the full width.
    always_comb begin
        unique case (size_of(fmt))
            SZ_BYTE: rdata = zero_ext(fmt) ? {24'b0, byte_v}
                                           : {{24{byte_v[7]}}, byte_v};
            SZ_HALF: rdata = zero_ext(fmt) ? {16'b0, half_v}
                                           : {{16{half_v[15]}}, half_v};
            default: rdata = word;
        endcase
    end
endmodule

// File: rtl/byte_lane_dmem.sv
// Module: byte-lane data memory (top).
// Storage is one byte bank per lane. Stores commit on the write-clock edge
// under per-lane strobes. Loads capture the word, lane and format on the
// read-clock edge and are extended afterwards. Assumes accesses do not
// cross a word boundary. Reset clears only the load path, not the storage.
module byte_lane_dmem
    import dmem_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic              rd_clk,
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic [31:0]       addr,
    input  logic [31:0]       wdata,
    input  logic              wen,
    input  logic [2:0]        fmt,
    output logic [31:0]       rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0]   widx;
    logic [LANES-1:0]   be;
    logic [DATA_W-1:0]  wlane;
    logic [DATA_W-1:0]  word_q;
    logic [LANE_AW-1:0] lane_q;
    logic [2:0]         fmt_q;

    assign widx = addr[IDX_W+1:2];

    dmem_lane_ctl u_lane_ctl (
        .lane  (addr[LANE_AW-1:0]),
        .wen   (wen),
        .fmt   (fmt),
        .wdata (wdata),
        .be    (be),
        .wlane (wlane)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [7:0] bank [DEPTH];

        // Purpose: commit this lane's byte when its strobe is set.
        always_ff @(posedge wr_clk) begin
            if (be[g]) begin
                bank[widx] <= wlane[g*8 +: 8];
            end
        end

        // Purpose: sample this lane's byte mid-cycle for the load.
        always_ff @(posedge rd_clk) begin
            if (!rst_n) begin
                word_q[g*8 +: 8] <= '0;
            end else begin
                word_q[g*8 +: 8] <= bank[widx];
            end
        end
    end

    // Purpose: capture the lane and the format together with the word.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            fmt_q  <= FMT_WORD;
        end else begin
            lane_q <= addr[LANE_AW-1:0];
            fmt_q  <= fmt;
        end
    end

    dmem_load_ext u_load_ext (
        .word  (word_q),
        .lane  (lane_q),
        .fmt   (fmt_q),
        .rdata (rdata)
    );

    // Store strobes against the format decoded at the ports.
    p_word_lanes_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wen && fmt == 3'b010) |-> (be == 4'hF))
        else $error("word store must enable every lane");

    p_byte_lane_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wen && fmt[1:0] == 2'b00) |-> ($countones(be) == 1 && be[addr[1:0]]))
        else $error("byte store must enable exactly the addressed lane");

    p_half_lane_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wen && fmt[1:0] == 2'b01) |-> (be == (addr[1] ? 4'b1100 : 4'b0011)))
        else $error("halfword store must enable the addressed half");

    p_no_write_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !wen |-> (be == '0))
        else $error("lane strobe set while store disabled");

    // Load extension seen one read edge later at the output.
    p_sext_byte_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (fmt == 3'b000) |=> (rdata[31:8] == {24{rdata[7]}}))
        else $error("signed byte load not sign extended");

    p_zext_byte_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (fmt == 3'b100) |=> (rdata[31:8] == 24'b0))
        else $error("unsigned byte load not zero extended");

    p_sext_half_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (fmt == 3'b001) |=> (rdata[31:16] == {16{rdata[15]}}))
        else $error("signed halfword load not sign extended");

    p_zext_half_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (fmt == 3'b101) |=> (rdata[31:16] == 16'b0))
        else $error("unsigned halfword load not zero extended");
endmodule

// File: tb/tb_byte_lane_dmem.sv
module tb_byte_lane_dmem;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wen = 1'b0;
    logic [2:0]  fmt = 3'b010;
    logic [31:0] rdata;
    logic        wr_clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    assign wr_clk = ~clk;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_lane_dmem #(.DEPTH(DEPTH)) dut (
        .rd_clk (clk),
        .wr_clk (wr_clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wdata  (wdata),
        .wen    (wen),
        .fmt    (fmt),
        .rdata  (rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %08h expected %08h", req, got, exp);
        end
    endtask

    // One processor cycle: drive after the falling edge, sample after the
    // rising edge (the load), and return once the store edge has passed.
    task automatic cycle(input logic [31:0] a, input logic [31:0] d, input logic we,
                         input logic [2:0] f, output logic [31:0] rd);
        @(negedge clk);
        #1;
        addr = a; wdata = d; wen = we; fmt = f;
        @(posedge clk);
        #1;
        rd = rdata;
        @(negedge clk);
        #1;
        wen = 1'b0;
    endtask

    task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [2:0] f);
        logic [31:0] unused;
        cycle(a, d, 1'b1, f, unused);
    endtask

    task automatic load(input logic [31:0] a, input logic [2:0] f, output logic [31:0] rd);
        cycle(a, 32'h0, 1'b0, f, rd);
    endtask

    task automatic t_reset();
        @(posedge clk);
        #1;
        check("R11 reset load data", rdata, 32'h0);
    endtask

    task automatic t_word();
        logic [31:0] r;
        store(32'h10, 32'hDEADBEEF, 3'b010);
        load(32'h10, 3'b010, r);
        check("R1 word store/load", r, 32'hDEADBEEF);
        cycle(32'h10, 32'h11223344, 1'b1, 3'b010, r);
        check("R10 same-cycle load sees old word", r, 32'hDEADBEEF);
        load(32'h10, 3'b010, r);
        check("R10 store visible next cycle", r, 32'h11223344);
    endtask

    task automatic t_bytes();
        logic [31:0] r;
        store(32'h20, 32'hA5A5A5A5, 3'b010);
        store(32'h21, 32'hFFFFFF7E, 3'b000);
        load(32'h20, 3'b010, r);
        check("R6 byte store lane 1 only", r, 32'hA5A57EA5);
        store(32'h23, 32'h00000011, 3'b100);
        load(32'h20, 3'b010, r);
        check("R6 byte store lane 3 only", r, 32'h11A57EA5);
        load(32'h21, 3'b000, r);
        check("R2 signed byte positive", r, 32'h0000007E);
        load(32'h22, 3'b000, r);
        check("R2 signed byte negative", r, 32'hFFFFFFA5);
        load(32'h22, 3'b100, r);
        check("R3 unsigned byte lane 2", r, 32'h000000A5);
        load(32'h20, 3'b100, r);
        check("R3 unsigned byte lane 0", r, 32'h000000A5);
        load(32'h23, 3'b100, r);
        check("R3 unsigned byte lane 3", r, 32'h00000011);
    endtask

    task automatic t_halves();
        logic [31:0] r;
        store(32'h30, 32'h00000000, 3'b010);
        store(32'h32, 32'h12348001, 3'b001);
        load(32'h30, 3'b010, r);
        check("R7 halfword store upper half only", r, 32'h80010000);
        store(32'h30, 32'hFFFF7FFF, 3'b101);
        load(32'h30, 3'b010, r);
        check("R7 halfword store lower half only", r, 32'h80017FFF);
        load(32'h32, 3'b001, r);
        check("R4 signed halfword negative", r, 32'hFFFF8001);
        load(32'h30, 3'b001, r);
        check("R4 signed halfword positive", r, 32'h00007FFF);
        load(32'h32, 3'b101, r);
        check("R5 unsigned halfword upper", r, 32'h00008001);
    endtask

    task automatic t_disabled();
        logic [31:0] r;
        store(32'h40, 32'h55AA55AA, 3'b010);
        cycle(32'h41, 32'hFFFFFFFF, 1'b0, 3'b000, r);
        cycle(32'h40, 32'h00000000, 1'b0, 3'b010, r);
        cycle(32'h42, 32'h00001234, 1'b0, 3'b001, r);
        load(32'h40, 3'b010, r);
        check("R9 disabled stores leave word", r, 32'h55AA55AA);
    endtask

    task automatic t_index();
        logic [31:0] r;
        store(32'h4, 32'hCAFEF00D, 3'b010);
        store(32'h8, 32'h0BADBEEF, 3'b010);
        load(32'h4 + DEPTH*4, 3'b010, r);
        check("R8 upper address bits ignored", r, 32'hCAFEF00D);
        load(32'h8, 3'b010, r);
        check("R8 neighbouring word independent", r, 32'h0BADBEEF);
        load(32'h4, 3'b010, r);
        check("R8 first word intact", r, 32'hCAFEF00D);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        addr = 32'h10; fmt = 3'b010;
        @(posedge clk);
        #1;
        check("R11 reset clears load data mid-run", rdata, 32'h0);
        @(negedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        t_word();
        t_bytes();
        t_halves();
        t_disabled();
        t_index();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule